// File: doc/BRIEF.md
# Command Queue Scan Trigger Controller

This block decides, cycle by cycle, whether one command FIFO may hand commands to a converter's command buffer. A three-bit mode input picks two things: the scan style, which is single pass or repeating, and the trigger source, which is a software pulse, a rising edge on an external pin, or a high level on that pin that gates the transfers. The external pin is resynchronised to the block clock. It then passes either straight through or through a glitch filter that accepts a new level only once the level has been held for a set number of clocks.

The FIFO offers each command on `cmd_valid_i` together with its end-of-queue flag `cmd_eoq_i`. The block answers on `cmd_ready_o`. A command moves on any clock edge where both are high. `cmd_ready_o` never depends on `cmd_valid_i`, and the FIFO holds its command until ready is seen. While the block is not triggered, ready stays low, and that low level is the only back-pressure this block applies. A transfer that carries the end-of-queue flag ends the scan. In single-scan modes the block then waits for a software rearm. In continuous modes it rearms by itself and waits for the next trigger.

Top module: `cq_scan_trig`

## Requirements
- R1: `mode_i[1:0]` selects the source: 00 disabled, 01 software, 10 rising edge, 11 high-level gated. `mode_i[2]`=1 selects continuous scan. While `mode_i[1:0]`=00, `status_o` reads 00 and `cmd_ready_o` is 0 in that same cycle.
- R2: The `status_o` codes are 00 disabled, 01 idle, 10 waiting for trigger and 11 triggered. `cmd_ready_o` is 1 only while `status_o` is 11.
- R3: In single-scan modes, a transfer that carries the end-of-queue flag moves the status to idle (01) on the next cycle. The status stays idle, ignoring all triggers, until `rearm_i` is high for one clock, which moves it to waiting (10).
- R4: In continuous modes, a transfer that carries the end-of-queue flag moves the status to waiting (10) on the next cycle. A new trigger then restarts the scan without `rearm_i`.
- R5: In software modes, `sw_trig_i` high while the status is waiting moves it to triggered on the next cycle. The external pin has no effect in these modes.
- R6: In edge modes with the filter bypassed, the status is still waiting after the second clock edge that follows a rise on `ext_trig_i`, and reads triggered after the third.
- R7: In gated modes, `cmd_ready_o` is high only while the filtered level is high. When the filtered level falls, ready drops in that cycle and the status returns to waiting on the next cycle. In continuous gated mode, the status returns to triggered one cycle after an end-of-queue transfer if the level is still high.
- R8: With `filt_byp_i`=0, a new synchronised level is accepted only after it has been held for FILT_LEN consecutive clocks. A pulse of FILT_LEN-1 clocks never triggers.
- R9: A trigger that arrives while the status is triggered or idle is discarded: it does not fire later. `sw_trig_i` has no effect in the external modes.
- R10: The cycle after a disabled mode, the status is not triggered. Enabling from disabled gives waiting after one clock, and a software trigger given during the disabled cycle is lost.
- R11: `cmd_ready_o` does not depend on `cmd_valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Scan style (bit 2) and trigger source (bits 1:0) |
| sw_trig_i | input | 1 | Software trigger pulse |
| rearm_i | input | 1 | Software rearm after a single scan |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| filt_byp_i | input | 1 | 1 bypasses the glitch filter |
| cmd_valid_i | input | 1 | FIFO offers a command |
| cmd_eoq_i | input | 1 | Offered command ends the queue |
| cmd_ready_o | output | 1 | Transfer enable, acts as ready to the FIFO |
| status_o | output | 2 | Scan status code |

## Verification
The hardest situation to reach is a rising edge that lands while a continuous edge-mode scan is still triggered and has not yet seen its end-of-queue flag. Such an edge must leave no trace once the scan rearms. Directed stimulus reaches it by holding the pin low and then high during the triggered phase, closing the queue while the pin is still high, and then checking that the status stays in waiting. Filtered pulses one clock shorter and exactly as long as the accept window are also driven directly. A long run of seeded random mode changes, pins and handshakes is compared every cycle against a model written in the bench.

// File: rtl/cqt_pkg.sv
package cqt_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ST_DIS  = 2'b00,
    ST_IDLE = 2'b01,
    ST_WAIT = 2'b10,
    ST_TRIG = 2'b11
  } scan_st_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_SW   = 2'b01,
    SRC_EDGE = 2'b10,
    SRC_GATE = 2'b11
  } trig_src_e;

  typedef struct packed {
    logic      cont;
    trig_src_e src;
  } mode_t;

  function automatic mode_t decode_mode(input logic [MODE_W-1:0] m);
    mode_t r;
    r.cont = m[2];
    r.src  = trig_src_e'(m[1:0]);
    return r;
  endfunction
endpackage

// File: rtl/cqt_trig_cond.sv
module cqt_trig_cond #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic byp_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   held_q;
  logic [CW-1:0]          cnt_q;
  logic                   lvl_d1_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= ext_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // Accept a new level only after FILT_LEN consecutive clocks of agreement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (byp_i) begin
      held_q <= synced;
      cnt_q  <= '0;
    end else if (synced != held_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        held_q <= synced;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign lvl_o = byp_i ? synced : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d1_q <= 1'b0;
    else        lvl_d1_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~lvl_d1_q;
endmodule

// File: rtl/cqt_scan_seq.sv
module cqt_scan_seq
  import cqt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode,
  input  logic             sw_trig,
  input  logic             rearm,
  input  logic             lvl,
  input  logic             rise,
  input  logic             xfer,
  input  logic             eoq,
  output logic             ready,
  output scan_st_e         status
);
  scan_st_e st_q, st_d;
  logic     en, fire;

  assign en = (mode.src != SRC_OFF);

  always_comb begin
    case (mode.src)
      SRC_SW:   fire = sw_trig;
      SRC_EDGE: fire = rise;
      SRC_GATE: fire = lvl;
      default:  fire = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_DIS;
    end else begin
      case (st_q)
        ST_DIS:  st_d = ST_WAIT;
        ST_IDLE: if (rearm) st_d = ST_WAIT;
        ST_WAIT: if (fire) st_d = ST_TRIG;
        ST_TRIG: begin
          if (xfer && eoq)                        st_d = mode.cont ? ST_WAIT : ST_IDLE;
          else if (mode.src == SRC_GATE && !lvl)  st_d = ST_WAIT;
        end
        default: st_d = ST_DIS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DIS;
    else        st_q <= st_d;
  end

  assign ready  = en && (st_q == ST_TRIG) && ((mode.src != SRC_GATE) || lvl);
  assign status = en ? st_q : ST_DIS;
endmodule

// File: rtl/cq_scan_trig.sv
module cq_scan_trig
  import cqt_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sw_trig_i,
  input  logic              rearm_i,
  input  logic              ext_trig_i,
  input  logic              filt_byp_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_eoq_i,
  output logic              cmd_ready_o,
  output logic [1:0]        status_o
);
  mode_t    mode;
  logic     trig_lvl, trig_rise, xfer;
  scan_st_e st;

  assign mode = decode_mode(mode_i);
  assign xfer = cmd_valid_i & cmd_ready_o;

  cqt_trig_cond #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_i  (ext_trig_i),
    .byp_i  (filt_byp_i),
    .lvl_o  (trig_lvl),
    .rise_o (trig_rise)
  );

  cqt_scan_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .sw_trig (sw_trig_i),
    .rearm   (rearm_i),
    .lvl     (trig_lvl),
    .rise    (trig_rise),
    .xfer    (xfer),
    .eoq     (cmd_eoq_i),
    .ready   (cmd_ready_o),
    .status  (st)
  );

  assign status_o = st;
endmodule

// File: rtl/cqt_checker.sv
module cqt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       rearm_i,
  input logic       cmd_valid_i,
  input logic       cmd_eoq_i,
  input logic       cmd_ready_o,
  input logic [1:0] status_o,
  input logic       trig_lvl
);
  p_dis_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1:0] == 2'b00) |-> (!cmd_ready_o && status_o == 2'b00));

  p_ready_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (status_o == 2'b11));

  p_single_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && cmd_eoq_i && !mode_i[2])
      |=> (status_o == 2'b01 || status_o == 2'b00));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b01 && !rearm_i) |=> (status_o == 2'b01 || status_o == 2'b00));

  p_cont_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && cmd_eoq_i && mode_i[2])
      |=> (status_o == 2'b10 || status_o == 2'b00));

  p_gate_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && mode_i[1:0] == 2'b11) |-> trig_lvl);

  p_no_trig_after_dis_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1:0] == 2'b00) |=> (status_o != 2'b11));
endmodule

bind cq_scan_trig cqt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .rearm_i     (rearm_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_eoq_i   (cmd_eoq_i),
  .cmd_ready_o (cmd_ready_o),
  .status_o    (status_o),
  .trig_lvl    (trig_lvl)
);

// File: tb/cq_scan_trig_tb_top.sv
module cq_scan_trig_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [1:0] S_DIS = 2'b00, S_IDLE = 2'b01, S_WAIT = 2'b10, S_TRIG = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic sw_trig_i = 0, rearm_i = 0, ext_trig_i = 0, filt_byp_i = 1;
  logic cmd_valid_i = 0, cmd_eoq_i = 0;
  logic cmd_ready_o;
  logic [1:0] status_o;

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R2";

  // bench model state
  logic m_s1 = 0, m_s2 = 0, m_held = 0, m_ld = 0;
  int   m_cnt = 0;
  logic [1:0] m_st = S_DIS;

  always #(CLK_PERIOD/2) clk = ~clk;

  cq_scan_trig #(.FILT_LEN(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sw_trig_i(sw_trig_i),
    .rearm_i(rearm_i), .ext_trig_i(ext_trig_i), .filt_byp_i(filt_byp_i),
    .cmd_valid_i(cmd_valid_i), .cmd_eoq_i(cmd_eoq_i),
    .cmd_ready_o(cmd_ready_o), .status_o(status_o)
  );

  function automatic logic m_lvl();
    return filt_byp_i ? m_s2 : m_held;
  endfunction

  function automatic logic m_ready();
    return (mode_i[1:0] != 2'b00) && (m_st == S_TRIG) &&
           ((mode_i[1:0] != 2'b11) || m_lvl());
  endfunction

  function automatic logic [1:0] m_status();
    return (mode_i[1:0] == 2'b00) ? S_DIS : m_st;
  endfunction

  task automatic model_step();
    logic lv, fire, nh, xfer;
    logic [1:0] ns;
    int nc;
    lv   = m_lvl();
    xfer = cmd_valid_i && m_ready();
    case (mode_i[1:0])
      2'b01:   fire = sw_trig_i;
      2'b10:   fire = lv && !m_ld;
      2'b11:   fire = lv;
      default: fire = 1'b0;
    endcase
    ns = m_st;
    if (mode_i[1:0] == 2'b00) ns = S_DIS;
    else case (m_st)
      S_DIS:  ns = S_WAIT;
      S_IDLE: if (rearm_i) ns = S_WAIT;
      S_WAIT: if (fire) ns = S_TRIG;
      default: begin
        if (xfer && cmd_eoq_i) ns = mode_i[2] ? S_WAIT : S_IDLE;
        else if (mode_i[1:0] == 2'b11 && !lv) ns = S_WAIT;
      end
    endcase
    nh = m_held; nc = m_cnt;
    if (filt_byp_i) begin nh = m_s2; nc = 0; end
    else if (m_s2 != m_held) begin
      if (m_cnt == N-1) begin nh = m_s2; nc = 0; end
      else nc = m_cnt + 1;
    end else nc = 0;
    m_st = ns; m_held = nh; m_cnt = nc; m_ld = lv;
    m_s2 = m_s1; m_s1 = ext_trig_i;
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: compare against model, advance
  task automatic cyc();
    #1;
    chk(cur_tag, {1'b0, cmd_ready_o}, {1'b0, m_ready()});
    chk(cur_tag, status_o, m_status());
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic cycn(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic see(input string tag, input logic [1:0] st, input logic rdy);
    #1;
    chk(tag, status_o, st);
    chk(tag, {1'b0, cmd_ready_o}, {1'b0, rdy});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    see("R1", S_DIS, 0);
    rst_n = 1'b1;

    // R10 enable from disabled
    cur_tag = "R10"; mode_i = 3'd1; cyc(); see("R10", S_WAIT, 0);
    // R11 / R2: ready low while waiting, valid present
    cmd_valid_i = 1; cur_tag = "R11"; cyc(); see("R2", S_WAIT, 0);
    // R5 software trigger
    cmd_valid_i = 0; sw_trig_i = 1; cur_tag = "R5"; cyc(); sw_trig_i = 0;
    see("R5", S_TRIG, 1); see("R11", S_TRIG, 1);
    // transfers without eoq keep triggered
    cmd_valid_i = 1; cur_tag = "R3"; cycn(2); see("R3", S_TRIG, 1);
    cmd_eoq_i = 1; cyc(); cmd_eoq_i = 0; cmd_valid_i = 0; see("R3", S_IDLE, 0);
    // R9: trigger while idle discarded
    sw_trig_i = 1; cur_tag = "R9"; cyc(); sw_trig_i = 0; cyc(); see("R9", S_IDLE, 0);
    rearm_i = 1; cur_tag = "R3"; cyc(); rearm_i = 0; see("R3", S_WAIT, 0);

    // R4 continuous software
    mode_i = 3'd5; sw_trig_i = 1; cur_tag = "R4"; cyc(); sw_trig_i = 0;
    cmd_valid_i = 1; cmd_eoq_i = 1; cyc(); cmd_valid_i = 0; cmd_eoq_i = 0;
    see("R4", S_WAIT, 0);
    sw_trig_i = 1; cyc(); sw_trig_i = 0; see("R4", S_TRIG, 1);

    // R1 disable drops ready same cycle; R10 discard
    mode_i = 3'd0; sw_trig_i = 1; see("R1", S_DIS, 0);
    cur_tag = "R1"; cyc(); sw_trig_i = 0;
    mode_i = 3'd1; cur_tag = "R10"; cyc(); cyc(); see("R10", S_WAIT, 0);

    // R6 edge, bypass; R9 sw ignored in ext mode
    mode_i = 3'd2; sw_trig_i = 1; cur_tag = "R9"; cyc(); sw_trig_i = 0; see("R9", S_WAIT, 0);
    ext_trig_i = 1; cur_tag = "R6"; cycn(2); see("R6", S_WAIT, 0);
    cyc(); see("R6", S_TRIG, 1);

    // R9 edge during triggered in continuous edge mode
    mode_i = 3'd6; cur_tag = "R9";
    ext_trig_i = 0; cycn(4); ext_trig_i = 1; cycn(4);
    see("R9", S_TRIG, 1);
    cmd_valid_i = 1; cmd_eoq_i = 1; cyc(); cmd_valid_i = 0; cmd_eoq_i = 0;
    cycn(4); see("R9", S_WAIT, 0);
    ext_trig_i = 0; cycn(4); ext_trig_i = 1; cur_tag = "R4"; cycn(3); see("R4", S_TRIG, 1);

    // R7 gated continuous
    mode_i = 3'd7; cur_tag = "R7"; cyc(); see("R7", S_TRIG, 1);
    cmd_valid_i = 1; cmd_eoq_i = 1; cyc(); cmd_valid_i = 0; cmd_eoq_i = 0;
    see("R7", S_WAIT, 0); cyc(); see("R7", S_TRIG, 1);
    ext_trig_i = 0; cycn(2); see("R7", S_TRIG, 0); cyc(); see("R7", S_WAIT, 0);
    ext_trig_i = 1; cycn(2); cyc(); see("R7", S_TRIG, 1);
    ext_trig_i = 0; cycn(4);

    // R8 filter
    filt_byp_i = 0; mode_i = 3'd0; cur_tag = "R8"; cyc(); mode_i = 3'd2; cyc();
    ext_trig_i = 1; cycn(N-1); ext_trig_i = 0; cycn(10); see("R8", S_WAIT, 0);
    ext_trig_i = 1; cycn(N+2); see("R8", S_WAIT, 0);
    cyc(); see("R8", S_TRIG, 1);

    // random phase
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) mode_i = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 59) == 0) filt_byp_i = ~filt_byp_i;
      if ($urandom_range(0, 5) == 0) ext_trig_i = ~ext_trig_i;
      sw_trig_i   = ($urandom_range(0, 3) == 0);
      rearm_i     = ($urandom_range(0, 7) == 0);
      cmd_valid_i = $urandom_range(0, 1) == 1;
      cmd_eoq_i   = ($urandom_range(0, 3) == 0);
      cyc();
    end
    finish_run();
  end
endmodule